// File: doc/BRIEF.md
# System Controller Register File

This block is the register file of a small system controller, reached over a simple 32-bit bus with byte addresses. It has three GPIO registers: a sampled input word, an output word that drives pins, and an interrupt-enable mask. It also has a configuration-port command register, a debug scratchpad that a one-way lock can freeze, and three read-only identity words that give the clock frequency, the capability flags and the system identifier. The bus forwards two blocks of three words to an external pair of timers.

Some writes are commands rather than stores. A write to the identity register asks for a system reset. A write of a particular command word to the configuration port asks for shutdown. A write of any data to the lock register sets a sticky bit. Each request leaves the block as a single-cycle pulse. A read returns its data in the cycle after the request.

Top module: `ctl_regfile`

## Requirements
- R1: After reset, reads return: configuration port 0x00000001 (ready flag in bit 0), identity 0x10014D31, clock frequency 80000000, capabilities 0, GPIO input the strap value 0x00000001, and 0 for GPIO output, interrupt enable, scratchpad and lock.
- R2: Only an access with all four byte enables set and a word-aligned address (address bits 1:0 zero) is accepted. Any other write changes nothing, and any other read returns 0.
- R3: GPIO output (word 1), interrupt enable (word 2) and scratchpad (word 20) read back the value written, and the GPIO output register drives the output pins.
- R4: Writes to GPIO input (word 0), clock frequency (word 29) and capabilities (word 30) are ignored.
- R5: Offsets outside the map (3, 7, 11 to 15, 17 to 19, 22 to 28) ignore writes and return 0 on reads.
- R6: A write to the configuration port (word 16) whose low 16 bits are 0x000E gives a one-cycle shutdown pulse in the cycle after the write. Other data gives no pulse. The port keeps reading 0x00000001.
- R7: Any write to the identity register (word 31) gives a one-cycle reset-request pulse in the cycle after the write, and the stored identity does not change.
- R8: Any write to the lock register (word 21) makes it read 1, whatever the data, and it stays 1 until reset.
- R9: While the lock reads 1, scratchpad writes are discarded.
- R10: When an input pin whose enable bit is set changes, the GPIO interrupt is high for one cycle, one cycle after the change. Changes on pins that are not enabled raise nothing.
- R11: An accepted access to words 4 to 6 or 8 to 10 raises the timer strobe in the same cycle. The strobe comes with the timer select (0 for 4 to 6, 1 for 8 to 10), the word index (address word bits 1:0) and the write flag. A read there returns the timer's data.
- R12: Read data appears in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| gpio_pins | input | GPIO_W | GPIO input pins |
| gpio_out | output | GPIO_W | GPIO output pins |
| gpio_irq | output | 1 | GPIO change interrupt pulse |
| tmr_stb | output | 1 | Timer register access strobe |
| tmr_we | output | 1 | Timer write flag |
| tmr_sel | output | 1 | Timer select |
| tmr_idx | output | 2 | Timer register index |
| tmr_wdata | output | 32 | Timer write data |
| tmr_rdata | input | 32 | Timer read data, valid with the strobe |
| sys_rst_req | output | 1 | System reset request pulse |
| shutdown_req | output | 1 | Shutdown request pulse |

## Verification
The hardest state to reach from the ports is a locked scratchpad that still holds a known earlier value. The stimulus writes the scratchpad and then sets the lock with arbitrary data. It then writes a different scratchpad value and reads back the first one. The interrupt's one-cycle timing is also awkward to reach. To test it, the stimulus moves single input pins between clock edges, once with the enable set and once with it clear, and watches the interrupt on the following two samples.

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int          GPIO_W  = 8,
  parameter int          AW      = 7,
  parameter logic [31:0] SYS_ID  = 32'h10014D31,
  parameter logic [31:0] CLK_HZ  = 32'd80000000,
  parameter logic [31:0] CAPS    = 32'h0,
  parameter logic [31:0] STRAP   = 32'h1,
  parameter logic [15:0] OFF_CMD = 16'h000E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [GPIO_W-1:0] gpio_pins,
  output logic [GPIO_W-1:0] gpio_out,
  output logic              gpio_irq,
  output logic              tmr_stb,
  output logic              tmr_we,
  output logic              tmr_sel,
  output logic [1:0]        tmr_idx,
  output logic [31:0]       tmr_wdata,
  input  logic [31:0]       tmr_rdata,
  output logic              sys_rst_req,
  output logic              shutdown_req
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_GIN  = WW'(0);
  localparam logic [WW-1:0] W_GOUT = WW'(1);
  localparam logic [WW-1:0] W_GIE  = WW'(2);
  localparam logic [WW-1:0] W_CFG  = WW'(16);
  localparam logic [WW-1:0] W_SCR  = WW'(20);
  localparam logic [WW-1:0] W_LOCK = WW'(21);
  localparam logic [WW-1:0] W_FREQ = WW'(29);
  localparam logic [WW-1:0] W_CAPS = WW'(30);
  localparam logic [WW-1:0] W_ID   = WW'(31);
  localparam logic [GPIO_W-1:0] STRAP_V = STRAP[GPIO_W-1:0];

  logic [GPIO_W-1:0] gin_q, gout_q, inten_q;
  logic [31:0]       scratch_q, rmux;
  logic              lock_q;

  wire [WW-1:0] word = bus_addr[AW-1:2];
  wire ok  = bus_req && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  wire wr  = ok && bus_we;
  wire rd  = ok && !bus_we;
  wire t0  = ((word >> 2) == WW'(1)) && (word[1:0] != 2'b11);
  wire t1  = ((word >> 2) == WW'(2)) && (word[1:0] != 2'b11);

  assign tmr_stb   = ok && (t0 || t1);
  assign tmr_we    = bus_we;
  assign tmr_sel   = t1;
  assign tmr_idx   = word[1:0];
  assign tmr_wdata = bus_wdata;
  assign gpio_out  = gout_q;

  always_comb begin
    rmux = 32'h0;
    if (t0 || t1) rmux = tmr_rdata;
    else begin
      case (word)
        W_GIN:   rmux = 32'(gin_q);
        W_GOUT:  rmux = 32'(gout_q);
        W_GIE:   rmux = 32'(inten_q);
        W_CFG:   rmux = 32'h1;
        W_SCR:   rmux = scratch_q;
        W_LOCK:  rmux = {31'h0, lock_q};
        W_FREQ:  rmux = CLK_HZ;
        W_CAPS:  rmux = CAPS;
        W_ID:    rmux = SYS_ID;
        default: rmux = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gin_q        <= STRAP_V;
      gout_q       <= '0;
      inten_q      <= '0;
      scratch_q    <= '0;
      lock_q       <= 1'b0;
      gpio_irq     <= 1'b0;
      sys_rst_req  <= 1'b0;
      shutdown_req <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      gin_q        <= gpio_pins;
      gpio_irq     <= |((gin_q ^ gpio_pins) & inten_q);
      sys_rst_req  <= wr && (word == W_ID);
      shutdown_req <= wr && (word == W_CFG) && (bus_wdata[15:0] == OFF_CMD);
      if (wr) begin
        case (word)
          W_GOUT: gout_q  <= bus_wdata[GPIO_W-1:0];
          W_GIE:  inten_q <= bus_wdata[GPIO_W-1:0];
          W_SCR:  if (!lock_q) scratch_q <= bus_wdata;
          W_LOCK: lock_q  <= 1'b1;
          default: ;
        endcase
      end
      if (bus_req && !bus_we) bus_rdata <= rd ? rmux : 32'h0;
    end
  end
endmodule

module ctl_regfile_chk #(
  parameter int GPIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_req,
  input logic              shutdown_req,
  input logic              lock_q,
  input logic [31:0]       scratch_q,
  input logic [GPIO_W-1:0] inten_q,
  input logic              gpio_irq,
  input logic              tmr_stb,
  input logic [3:0]        bus_be
);
  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  p_shut_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_scratch_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(scratch_q));
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inten_q == '0) |=> !gpio_irq);
  p_tmr_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_stb |-> (bus_be == 4'hF));
endmodule

bind ctl_regfile ctl_regfile_chk #(.GPIO_W(GPIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req),
  .shutdown_req(shutdown_req), .lock_q(lock_q), .scratch_q(scratch_q),
  .inten_q(inten_q), .gpio_irq(gpio_irq), .tmr_stb(tmr_stb), .bus_be(bus_be));

// File: tb/ctl_regfile_tb_top.sv
module ctl_regfile_tb_top;
  localparam int CLK_P = 10;
  localparam int GW = 8;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [6:0] bus_addr = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, tmr_wdata, tmr_rdata;
  logic [GW-1:0] gpio_pins = 8'h01, gpio_out;
  logic gpio_irq, tmr_stb, tmr_we, tmr_sel, sys_rst_req, shutdown_req;
  logic [1:0] tmr_idx;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #(CLK_P/2) clk = ~clk;
  assign tmr_rdata = 32'hC0DE0000 | {29'h0, tmr_sel, tmr_idx};

  ctl_regfile dut_i (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_pins(gpio_pins), .gpio_out(gpio_out), .gpio_irq(gpio_irq),
    .tmr_stb(tmr_stb), .tmr_we(tmr_we), .tmr_sel(tmr_sel), .tmr_idx(tmr_idx),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
    .sys_rst_req(sys_rst_req), .shutdown_req(shutdown_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int w, logic [31:0] d, logic [3:0] be = 4'hF, logic [1:0] lo = 0);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 7'(w * 4) | 7'(lo); bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(int w, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 7'(w * 4); bus_be = be;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    rd(16, rv); chk("R1 cfg", rv, 32'h1);
    rd(31, rv); chk("R1 id", rv, 32'h10014D31);
    rd(29, rv); chk("R1 freq", rv, 32'd80000000);
    rd(30, rv); chk("R1 caps", rv, 0);
    rd(0, rv);  chk("R1 gpio in", rv, 32'h1);
    rd(20, rv); chk("R1 scratch", rv, 0);
    rd(21, rv); chk("R1 lock", rv, 0);
    rd(1, rv);  chk("R1 gpio out", rv, 0);
  endtask

  task automatic t_rw;
    wr(1, 32'h0000005A); rd(1, rv); chk("R3 gout", rv, 32'h5A);
    chk("R3 pins", 32'(gpio_out), 32'h5A);
    wr(2, 32'h000000F0); rd(2, rv); chk("R3 inten", rv, 32'hF0);
    wr(20, 32'hDEADBEEF); rd(20, rv); chk("R3 scratch", rv, 32'hDEADBEEF);
    wr(2, 0);
  endtask

  task automatic t_partial;
    wr(20, 32'h11111111, 4'h3); rd(20, rv); chk("R2 partial wr", rv, 32'hDEADBEEF);
    wr(20, 32'h22222222, 4'hF, 2'b10); rd(20, rv); chk("R2 misaligned wr", rv, 32'hDEADBEEF);
    rd(31, rv, 4'h1); chk("R2 partial rd", rv, 0);
  endtask

  task automatic t_readonly;
    wr(0, 32'hFFFFFFFF); rd(0, rv); chk("R4 gin", rv, 32'h1);
    wr(29, 32'h1234); rd(29, rv); chk("R4 freq", rv, 32'd80000000);
    wr(30, 32'h55); rd(30, rv); chk("R4 caps", rv, 0);
  endtask

  task automatic t_undef;
    wr(3, 32'hAAAA5555); rd(3, rv); chk("R5 off3", rv, 0);
    wr(25, 32'h1); rd(25, rv); chk("R5 off25", rv, 0);
    rd(7, rv); chk("R5 off7", rv, 0);
    rd(18, rv); chk("R5 off18", rv, 0);
  endtask

  task automatic t_shutdown;
    wr(16, 32'hFFFF000E);
    chk("R6 pulse", 32'(shutdown_req), 1);
    @(negedge clk); chk("R6 one cycle", 32'(shutdown_req), 0);
    wr(16, 32'h0000000F);
    chk("R6 other word", 32'(shutdown_req), 0);
    rd(16, rv); chk("R6 cfg ready", rv, 32'h1);
  endtask

  task automatic t_sysrst;
    wr(31, 32'h0);
    chk("R7 pulse", 32'(sys_rst_req), 1);
    @(negedge clk); chk("R7 one cycle", 32'(sys_rst_req), 0);
    rd(31, rv); chk("R7 id kept", rv, 32'h10014D31);
  endtask

  task automatic t_lock;
    wr(20, 32'h0BADF00D);
    wr(21, 32'h0);
    rd(21, rv); chk("R8 lock set", rv, 1);
    wr(21, 32'hFFFFFFFF); rd(21, rv); chk("R8 lock sticky", rv, 1);
    wr(20, 32'h12345678); rd(20, rv); chk("R9 scratch frozen", rv, 32'h0BADF00D);
  endtask

  task automatic t_irq;
    wr(2, 32'h02);
    @(negedge clk); gpio_pins = 8'h03;
    @(negedge clk); chk("R10 irq", 32'(gpio_irq), 1);
    @(negedge clk); chk("R10 irq one cycle", 32'(gpio_irq), 0);
    gpio_pins = 8'h02;
    @(negedge clk); chk("R10 masked bit", 32'(gpio_irq), 0);
    @(negedge clk); chk("R10 masked bit later", 32'(gpio_irq), 0);
  endtask

  task automatic t_timer;
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 7'(10 * 4); bus_be = 4'hF; bus_wdata = 32'h77;
    #1;
    chk("R11 strobe", 32'(tmr_stb), 1);
    chk("R11 select", {tmr_we, tmr_sel, tmr_idx}, 32'b1110);
    chk("R11 wdata", tmr_wdata, 32'h77);
    @(negedge clk); bus_req = 0; bus_we = 0;
    #1; chk("R11 idle", 32'(tmr_stb), 0);
    rd(9, rv); chk("R11 rd t1", rv, 32'hC0DE0005);
    rd(4, rv); chk("R11 rd t0", rv, 32'hC0DE0000);
    @(negedge clk); bus_req = 1; bus_addr = 7'(7 * 4); #1;
    chk("R11 gap no strobe", 32'(tmr_stb), 0);
    @(negedge clk); bus_req = 0;
  endtask

  task automatic t_latency;
    rd(31, rv);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 7'(29 * 4); bus_be = 4'hF;
    #1; chk("R12 not yet", bus_rdata, 32'h10014D31);
    @(negedge clk); bus_req = 0;
    chk("R12 one cycle", bus_rdata, 32'd80000000);
    @(negedge clk); chk("R12 hold", bus_rdata, 32'd80000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_rw; t_partial; t_readonly; t_undef;
    t_shutdown; t_sysrst; t_lock; t_irq; t_timer; t_latency;
    rst_n = 0; @(negedge clk); rst_n = 1;
    rd(21, rv); chk("R8 cleared by reset", rv, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule